// File: doc/BRIEF.md
# Raster Timing Generator

This block produces the scan timing for a 1280x1024 display refreshed at 60 Hz. It runs from a single pixel clock of about 108 MHz, because 1688 x 1066 x 60 is about 107.96 MHz. A synchronous reset puts it at the top-left visible pixel. It drives a horizontal position and a vertical position, active-high horizontal and vertical sync, a blanking flag, and two strobes. One strobe marks the final visible column and the other marks the final visible row. A downstream pixel pipeline uses the positions to address colour data and uses the strobes and blanking to frame it.

Each axis has its own position counter and a four-state phase machine. The states are VISIBLE, FRONT (front porch), SYNC and BACK (back porch). The transitions, each on a step of the counter, are:

- VISIBLE to FRONT after the last visible position.
- FRONT to SYNC after the last front-porch position.
- SYNC to BACK after the last sync position.
- BACK to VISIBLE on wrap.

The horizontal axis steps on every clock. The vertical axis steps when the horizontal axis wraps. The sync, blanking and strobe outputs decode from the registered phase, so they change in the same cycle as the positions. Every interval length is a parameter, and the defaults give the 1688 x 1066 raster.

Top module: `raster_timing_gen`

## Requirements
- R1: `hcount` rises by one on every clock from 0 to H_TOTAL-1 (1687) and then returns to 0.
- R2: `vcount` rises by one only on a clock where `hcount` is H_TOTAL-1, and holds otherwise. It returns to 0 after V_TOTAL-1 (1065).
- R3: `blank` is 1 exactly when `hcount` >= H_ACTIVE (1280) or `vcount` >= V_ACTIVE (1024).
- R4: `hsync` is 1 (active high) exactly when `hcount` is in H_ACTIVE+H_FRONT .. H_ACTIVE+H_FRONT+H_PULSE-1 (1328..1439).
- R5: `vsync` is 1 (active high) exactly when `vcount` is in V_ACTIVE+V_FRONT .. V_ACTIVE+V_FRONT+V_PULSE-1 (1025..1027).
- R6: `last_column` is 1 exactly when `hcount` equals H_ACTIVE-1 (1279).
- R7: `last_row` is 1 exactly when `vcount` equals V_ACTIVE-1 (1023).
- R8: `rst` sampled high on a clock edge sets both counts to 0. In the first cycle after release, the outputs show position (0,0) with `blank` low, and counting then restarts from there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| hcount | output | $clog2(H_TOTAL) (11) | Horizontal position |
| vcount | output | $clog2(V_TOTAL) (11) | Vertical position |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| blank | output | 1 | High outside the visible area |
| last_column | output | 1 | High on the final visible column |
| last_row | output | 1 | High on the final visible row |

## Verification
The bench builds the block with a small raster:

- Horizontal: 16 visible, 3 front porch, 4 sync, 30 total.
- Vertical: 8 visible, 1 front porch, 3 sync, 14 total.

With a frame of 420 clocks instead of about 1.8 million, every phase transition on both axes can be checked cycle by cycle, including the vertical wrap and repeated frames. A front porch of one line exercises the shortest FRONT interval. A reset in the middle of a line shows that both the counters and the phase machines restart together.

// File: rtl/raster_pkg.sv
package raster_pkg;

    // Phase of one scan axis; the order follows the scan sequence.
    typedef enum logic [1:0] {
        PH_VISIBLE = 2'd0,
        PH_FRONT   = 2'd1,
        PH_SYNC    = 2'd2,
        PH_BACK    = 2'd3
    } raster_phase_e;

endpackage

// File: rtl/raster_axis.sv
module raster_axis
    import raster_pkg::*;
#(
    parameter int ACTIVE = 1280,
    parameter int FRONT  = 48,
    parameter int PULSE  = 112,
    parameter int TOTAL  = 1688,
    parameter int W      = $clog2(TOTAL)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         adv,
    output logic [W-1:0] count,
    output logic         in_visible,
    output logic         in_sync,
    output logic         on_last_visible,
    output logic         on_wrap
);

    localparam logic [W-1:0] VIS_END   = W'(ACTIVE - 1);
    localparam logic [W-1:0] FRONT_END = W'(ACTIVE + FRONT - 1);
    localparam logic [W-1:0] SYNC_END  = W'(ACTIVE + FRONT + PULSE - 1);
    localparam logic [W-1:0] WRAP_AT   = W'(TOTAL - 1);

    raster_phase_e state_q, state_d;
    logic [W-1:0]  cnt_q, cnt_d;

    // State and position registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_VISIBLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next position and phase transitions.
    always_comb begin
        cnt_d   = cnt_q;
        state_d = state_q;
        if (adv) begin
            cnt_d = (cnt_q == WRAP_AT) ? '0 : cnt_q + 1'b1;
            unique case (state_q)
                PH_VISIBLE: if (cnt_q == VIS_END)   state_d = PH_FRONT;
                PH_FRONT:   if (cnt_q == FRONT_END) state_d = PH_SYNC;
                PH_SYNC:    if (cnt_q == SYNC_END)  state_d = PH_BACK;
                PH_BACK:    if (cnt_q == WRAP_AT)   state_d = PH_VISIBLE;
                default:                            state_d = PH_VISIBLE;
            endcase
        end
    end

    // Outputs from the registered phase.
    always_comb begin
        in_visible      = 1'b0;
        in_sync         = 1'b0;
        on_last_visible = 1'b0;
        unique case (state_q)
            PH_VISIBLE: begin
                in_visible      = 1'b1;
                on_last_visible = (cnt_q == VIS_END);
            end
            PH_SYNC:  in_sync = 1'b1;
            PH_FRONT,
            PH_BACK:  ;
            default:  ;
        endcase
        on_wrap = (cnt_q == WRAP_AT);
        count   = cnt_q;
    end

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen #(
    parameter int H_ACTIVE = 1280,
    parameter int H_FRONT  = 48,
    parameter int H_PULSE  = 112,
    parameter int H_TOTAL  = 1688,
    parameter int V_ACTIVE = 1024,
    parameter int V_FRONT  = 1,
    parameter int V_PULSE  = 3,
    parameter int V_TOTAL  = 1066,
    localparam int HW = $clog2(H_TOTAL),
    localparam int VW = $clog2(V_TOTAL)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [HW-1:0] hcount,
    output logic [VW-1:0] vcount,
    output logic          hsync,
    output logic          vsync,
    output logic          blank,
    output logic          last_column,
    output logic          last_row
);

    logic h_visible, h_sync, h_last, h_wrap;
    logic v_visible, v_sync, v_last, v_wrap;

    raster_axis #(
        .ACTIVE(H_ACTIVE), .FRONT(H_FRONT), .PULSE(H_PULSE),
        .TOTAL(H_TOTAL), .W(HW)
    ) h_axis_i (
        .clk             (clk),
        .rst             (rst),
        .adv             (1'b1),
        .count           (hcount),
        .in_visible      (h_visible),
        .in_sync         (h_sync),
        .on_last_visible (h_last),
        .on_wrap         (h_wrap)
    );

    raster_axis #(
        .ACTIVE(V_ACTIVE), .FRONT(V_FRONT), .PULSE(V_PULSE),
        .TOTAL(V_TOTAL), .W(VW)
    ) v_axis_i (
        .clk             (clk),
        .rst             (rst),
        .adv             (h_wrap),
        .count           (vcount),
        .in_visible      (v_visible),
        .in_sync         (v_sync),
        .on_last_visible (v_last),
        .on_wrap         (v_wrap)
    );

    always_comb begin
        hsync       = h_sync;
        vsync       = v_sync;
        blank       = !(h_visible && v_visible);
        last_column = h_last;
        last_row    = v_last;
    end

    logic unused_v_wrap;
    assign unused_v_wrap = v_wrap;

endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk #(
    parameter int H_ACTIVE = 1280,
    parameter int H_FRONT  = 48,
    parameter int H_PULSE  = 112,
    parameter int H_TOTAL  = 1688,
    parameter int V_ACTIVE = 1024,
    parameter int V_FRONT  = 1,
    parameter int V_PULSE  = 3,
    parameter int V_TOTAL  = 1066,
    localparam int HW = $clog2(H_TOTAL),
    localparam int VW = $clog2(V_TOTAL)
) (
    input logic          clk,
    input logic          rst,
    input logic [HW-1:0] hcount,
    input logic [VW-1:0] vcount,
    input logic          hsync,
    input logic          vsync,
    input logic          blank,
    input logic          last_column,
    input logic          last_row
);

    localparam logic [HW-1:0] H_LAST  = HW'(H_TOTAL - 1);
    localparam logic [VW-1:0] V_LAST  = VW'(V_TOTAL - 1);
    localparam logic [HW-1:0] H_SS    = HW'(H_ACTIVE + H_FRONT);
    localparam logic [VW-1:0] V_SS    = VW'(V_ACTIVE + V_FRONT);
    localparam logic [HW-1:0] H_VIS   = HW'(H_ACTIVE);
    localparam logic [VW-1:0] V_VIS   = VW'(V_ACTIVE);
    localparam logic [HW-1:0] H_VEND  = HW'(H_ACTIVE - 1);
    localparam logic [VW-1:0] V_VEND  = VW'(V_ACTIVE - 1);

    // R1
    h_step_chk: assert property (@(posedge clk) disable iff (rst)
        (hcount != H_LAST) |=> (hcount == $past(hcount) + 1'b1));

    // R1
    h_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (hcount == H_LAST) |=> (hcount == '0));

    // R2
    v_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (hcount != H_LAST) |=> $stable(vcount));

    // R2
    v_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (hcount == H_LAST && vcount == V_LAST) |=> (vcount == '0));

    // R3
    blank_vis_chk: assert property (@(posedge clk) disable iff (rst)
        !blank |-> (hcount < H_VIS && vcount < V_VIS));

    // R4
    hsync_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hsync) |-> (hcount == H_SS));

    // R5
    vsync_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(vsync) |-> (vcount == V_SS));

    // R6
    last_col_chk: assert property (@(posedge clk) disable iff (rst)
        last_column |-> (hcount == H_VEND));

    // R7
    last_row_chk: assert property (@(posedge clk) disable iff (rst)
        last_row |-> (vcount == V_VEND));

    // R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (hcount == '0 && vcount == '0));

endmodule

bind raster_timing_gen raster_timing_chk #(
    .H_ACTIVE(H_ACTIVE), .H_FRONT(H_FRONT), .H_PULSE(H_PULSE), .H_TOTAL(H_TOTAL),
    .V_ACTIVE(V_ACTIVE), .V_FRONT(V_FRONT), .V_PULSE(V_PULSE), .V_TOTAL(V_TOTAL)
) chk_i (
    .clk(clk), .rst(rst), .hcount(hcount), .vcount(vcount),
    .hsync(hsync), .vsync(vsync), .blank(blank),
    .last_column(last_column), .last_row(last_row)
);

// File: tb/raster_timing_gen_tb_top.sv
module raster_timing_gen_tb_top;

    localparam int HA = 16, HF = 3, HP = 4, HT = 30;
    localparam int VA = 8,  VF = 1, VP = 3, VT = 14;
    localparam int HW = $clog2(HT);
    localparam int VW = $clog2(VT);

    typedef struct {
        int h; int v; bit hs; bit vs; bit bl; bit lc; bit lr;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [HW-1:0] hcount;
    logic [VW-1:0] vcount;
    logic          hsync, vsync, blank, last_column, last_row;

    exp_t q[$];
    bit   mon_en = 1'b0;
    bit   done   = 1'b0;
    int   n_chk  = 0;
    int   n_bad  = 0;

    always #5 clk = ~clk;

    raster_timing_gen #(
        .H_ACTIVE(HA), .H_FRONT(HF), .H_PULSE(HP), .H_TOTAL(HT),
        .V_ACTIVE(VA), .V_FRONT(VF), .V_PULSE(VP), .V_TOTAL(VT)
    ) dut_i (
        .clk(clk), .rst(rst), .hcount(hcount), .vcount(vcount),
        .hsync(hsync), .vsync(vsync), .blank(blank),
        .last_column(last_column), .last_row(last_row)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    // Driver: expected outputs for cycle n after reset release.
    task automatic push_expected(input int ncyc);
        for (int n = 0; n < ncyc; n++) begin
            exp_t e;
            e.h  = n % HT;
            e.v  = (n / HT) % VT;
            e.hs = (e.h >= HA + HF) && (e.h < HA + HF + HP);
            e.vs = (e.v >= VA + VF) && (e.v < VA + VF + VP);
            e.bl = (e.h >= HA) || (e.v >= VA);
            e.lc = (e.h == HA - 1);
            e.lr = (e.v == VA - 1);
            q.push_back(e);
        end
    endtask

    // Monitor: compare away from the active edge.
    always @(negedge clk) begin
        if (mon_en && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(int'(hcount) == e.h, "R1 hcount", int'(hcount), e.h);
            chk(int'(vcount) == e.v, "R2 vcount", int'(vcount), e.v);
            chk(blank == e.bl, "R3 blank", int'(blank), int'(e.bl));
            chk(hsync == e.hs, "R4 hsync", int'(hsync), int'(e.hs));
            chk(vsync == e.vs, "R5 vsync", int'(vsync), int'(e.vs));
            chk(last_column == e.lc, "R6 last_column", int'(last_column), int'(e.lc));
            chk(last_row == e.lr, "R7 last_row", int'(last_row), int'(e.lr));
        end
    end

    task automatic run_segment(input int ncyc);
        mon_en = 1'b0;
        q.delete();
        @(posedge clk);
        #1 rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        // R8: counters cleared while reset is held
        chk(hcount == '0 && vcount == '0, "R8 reset clear",
            int'(hcount) * 1000 + int'(vcount), 0);
        @(posedge clk);
        #1 rst = 1'b0;
        push_expected(ncyc);
        mon_en = 1'b1;
        while (q.size() > 0) @(posedge clk);
        @(negedge clk);
        mon_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        // Two full frames plus a few cycles of the third.
        run_segment(2 * HT * VT + 45);
        // Reset in mid-line, then restart (R8).
        repeat (7) @(posedge clk);
        run_segment(HT * 3 + 11);
        finish_run();
    end

    initial begin
        #200000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

endmodule